// File: doc/BRIEF.md
# Dual-Channel Programmable Pulse Generator

This block drives two pins with repeating pulses for status lamps, keep-alive strobes and other slow periodic signals. Each channel waits through a start delay, then repeats a period in which its output is active for an on-time at the start. Delay, on-time and period are 8-bit counts. They advance on one of two timebase ticks supplied from outside: a fast tick (nominally 1 ms) or a slow tick (nominally 125 ms). With the slow tick the longest period is 255 × 125 ms, which is 31.875 s.

Software-style configuration arrives on a flat bus qualified by a single write strobe. One write loads every field of both channels, so both channels can be started on the same clock edge. Their phase difference then equals the difference of their delay values. A channel that is already running keeps its phase when it is rewritten with its enable still set. To realign it, software first disables both channels and then enables both in one write. Each channel has its own polarity inversion and its own pin output-enable gate.

Top module: `twin_pulse_gen`

## Requirements
- R1: One edge with `cfgWr` high loads the fields of every channel. Each idle channel whose enable bit is set in that write starts on that edge, so channels started together keep a phase offset equal to their delay difference.
- R2: After a start, the output stays inactive for `delay` period-ticks and then goes active. A delay of 0 makes the output active on the start edge, provided the on-time and the period are non-zero.
- R3: While running, each period lasts `period` period-ticks. When the on-time and period ticks are the same, the output is active for the first `onTime` ticks of each period, and the pattern repeats without end.
- R4: An on-time of 0 gives a constant inactive output. An on-time equal to or larger than the period gives a constant active output (same tick for both). A period of 0 holds the output inactive.
- R5: Per channel, `cfgPrdSlow` selects the tick that clocks both the period counter and the delay counter, and `cfgOnSlow` selects the tick for the on-time counter. In each field, 0 selects `fastTick` and 1 selects `slowTick`.
- R6: With the invert bit set, the pin level is the complement of the non-inverted level. The inactive level is then 1.
- R7: With a pin's output-enable bit clear, that pin is driven 0 whatever the channel state.
- R8: The combination on-time slow with period fast is unsupported. For it, `cfgErr` for that channel is 1 and the output is held at its inactive level. `cfgErr` is 0 for the three other combinations.
- R9: A write with a channel's enable bit clear stops that channel. From the next cycle its counters are cleared and its output is at its inactive level. A later enabling write restarts it from the delay phase. After reset, all outputs and flags are 0.
- R10: A write with the enable bit set to a channel that is already running does not restart it. Its counters continue from their current values.
- R11: With no tick and no write, the pin outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fastTick | input | 1 | Fine timebase tick, one cycle wide |
| slowTick | input | 1 | Coarse timebase tick, one cycle wide |
| cfgWr | input | 1 | Write strobe; loads all configuration fields |
| cfgEnable | input | NUM_CH | Per-channel enable |
| cfgDelay | input | NUM_CH*CNT_W | Start delay per channel, channel c at bits [c*CNT_W +: CNT_W] |
| cfgOnTime | input | NUM_CH*CNT_W | On-time per channel, same packing |
| cfgPeriod | input | NUM_CH*CNT_W | Period per channel, same packing |
| cfgOnSlow | input | NUM_CH | On-time tick select (1 = slow) |
| cfgPrdSlow | input | NUM_CH | Period and delay tick select (1 = slow) |
| cfgInvert | input | NUM_CH | Output polarity inversion |
| cfgPinOe | input | NUM_CH | Pin output enable |
| pulseOut | output | NUM_CH | Gated pulse pins |
| cfgErr | output | NUM_CH | Unsupported tick combination flag |

## Verification
Some behaviours are checked on every cycle by the assertions. An erroneous tick selection, a stopped channel and a closed output-enable gate each pin the output to a fixed level. A disabling write forces the inactive level on the following cycle. The pins hold steady in any cycle with neither a tick nor a write. Other behaviours only the bench's scenarios can show. These are the length of the delay, the on/off pattern across whole periods, the alignment of two channels started in one write, the split between on-time and period ticks, and the lack of a restart when a running channel is rewritten. The bench shows them by comparing each pin, after every tick, against a count derived arithmetically from the configuration.

// File: rtl/twin_pulse_pkg.sv
package twin_pulse_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrAll;     // zero every counter
    logic delayStep;  // advance the start-delay counter
    logic prdStep;    // advance the period counter
    logic prdWrap;    // period complete: restart period and on-time counters
    logic onStep;     // advance the on-time counter
  } strobe_t;

endpackage

// File: rtl/twin_pulse_ctrl.sv
module twin_pulse_ctrl
  import twin_pulse_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    enIn,
  input  logic    newDelayZero,
  input  logic    prdTick,
  input  logic    onTick,
  input  logic    delayLast,
  input  logic    prdLast,
  input  logic    onFull,
  output strobe_t st,
  output logic    running
);

  phase_t phase, phaseNext;
  logic   startCh, stopCh, delayDone;

  assign startCh   = load && enIn && (phase == PH_IDLE);
  assign stopCh    = load && !enIn;
  assign delayDone = (phase == PH_DELAY) && prdTick && delayLast;

  always_comb begin
    phaseNext = phase;
    if (stopCh)         phaseNext = PH_IDLE;
    else if (startCh)   phaseNext = newDelayZero ? PH_RUN : PH_DELAY;
    else if (delayDone) phaseNext = PH_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phaseNext;
  end

  always_comb begin
    st           = '0;
    st.clrAll    = startCh || stopCh || delayDone;
    st.delayStep = (phase == PH_DELAY) && prdTick && !delayLast;
    st.prdWrap   = (phase == PH_RUN) && prdTick && prdLast;
    st.prdStep   = (phase == PH_RUN) && prdTick && !prdLast;
    st.onStep    = (phase == PH_RUN) && onTick && !onFull && !st.prdWrap;
  end

  assign running = (phase == PH_RUN);

endmodule

// File: rtl/twin_pulse_dp.sv
module twin_pulse_dp
  import twin_pulse_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] delayIn,
  input  logic [CNT_W-1:0] onIn,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             onSlowIn,
  input  logic             prdSlowIn,
  input  logic             invIn,
  input  logic             oeIn,
  input  logic             fastTick,
  input  logic             slowTick,
  input  strobe_t          st,
  input  logic             running,
  output logic             newDelayZero,
  output logic             prdTick,
  output logic             onTick,
  output logic             delayLast,
  output logic             prdLast,
  output logic             onFull,
  output logic             err,
  output logic             invQ,
  output logic             oeQ,
  output logic             pin
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] delayQ, onQ, prdQ;
  logic             onSlowQ, prdSlowQ;
  logic [CNT_W-1:0] delayCnt, prdCnt, onCnt;
  logic             active;

  // configuration holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delayQ   <= '0;
      onQ      <= '0;
      prdQ     <= '0;
      onSlowQ  <= 1'b0;
      prdSlowQ <= 1'b0;
      invQ     <= 1'b0;
      oeQ      <= 1'b0;
    end else if (load) begin
      delayQ   <= delayIn;
      onQ      <= onIn;
      prdQ     <= periodIn;
      onSlowQ  <= onSlowIn;
      prdSlowQ <= prdSlowIn;
      invQ     <= invIn;
      oeQ      <= oeIn;
    end
  end

  assign newDelayZero = (delayIn == '0);
  assign prdTick      = prdSlowQ ? slowTick : fastTick;
  assign onTick       = onSlowQ  ? slowTick : fastTick;

  // counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delayCnt <= '0;
      prdCnt   <= '0;
      onCnt    <= '0;
    end else if (st.clrAll) begin
      delayCnt <= '0;
      prdCnt   <= '0;
      onCnt    <= '0;
    end else begin
      if (st.delayStep) delayCnt <= delayCnt + ONE;
      if (st.prdWrap) begin
        prdCnt <= '0;
        onCnt  <= '0;
      end else begin
        if (st.prdStep) prdCnt <= prdCnt + ONE;
        if (st.onStep)  onCnt  <= onCnt + ONE;
      end
    end
  end

  assign delayLast = (delayQ != '0) && (delayCnt == delayQ - ONE);
  assign prdLast   = (prdQ != '0) && (prdCnt == prdQ - ONE);
  assign onFull    = (onCnt >= onQ);

  assign err    = onSlowQ && !prdSlowQ;
  assign active = running && !err && (prdQ != '0) && (onCnt < onQ);
  assign pin    = oeQ && (active ^ invQ);

endmodule

// File: rtl/twin_pulse_gen.sv
module twin_pulse_gen
  import twin_pulse_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fastTick,
  input  logic                    slowTick,
  input  logic                    cfgWr,
  input  logic [NUM_CH-1:0]       cfgEnable,
  input  logic [NUM_CH*CNT_W-1:0] cfgDelay,
  input  logic [NUM_CH*CNT_W-1:0] cfgOnTime,
  input  logic [NUM_CH*CNT_W-1:0] cfgPeriod,
  input  logic [NUM_CH-1:0]       cfgOnSlow,
  input  logic [NUM_CH-1:0]       cfgPrdSlow,
  input  logic [NUM_CH-1:0]       cfgInvert,
  input  logic [NUM_CH-1:0]       cfgPinOe,
  output logic [NUM_CH-1:0]       pulseOut,
  output logic [NUM_CH-1:0]       cfgErr
);

  logic [NUM_CH-1:0] chRun, chInv, chOe;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    strobe_t st;
    logic    newDelayZero, prdTick, onTick, delayLast, prdLast, onFull;

    twin_pulse_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (cfgWr),
      .enIn         (cfgEnable[gi]),
      .newDelayZero (newDelayZero),
      .prdTick      (prdTick),
      .onTick       (onTick),
      .delayLast    (delayLast),
      .prdLast      (prdLast),
      .onFull       (onFull),
      .st           (st),
      .running      (chRun[gi])
    );

    twin_pulse_dp #(.CNT_W(CNT_W)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (cfgWr),
      .delayIn      (cfgDelay[gi*CNT_W +: CNT_W]),
      .onIn         (cfgOnTime[gi*CNT_W +: CNT_W]),
      .periodIn     (cfgPeriod[gi*CNT_W +: CNT_W]),
      .onSlowIn     (cfgOnSlow[gi]),
      .prdSlowIn    (cfgPrdSlow[gi]),
      .invIn        (cfgInvert[gi]),
      .oeIn         (cfgPinOe[gi]),
      .fastTick     (fastTick),
      .slowTick     (slowTick),
      .st           (st),
      .running      (chRun[gi]),
      .newDelayZero (newDelayZero),
      .prdTick      (prdTick),
      .onTick       (onTick),
      .delayLast    (delayLast),
      .prdLast      (prdLast),
      .onFull       (onFull),
      .err          (cfgErr[gi]),
      .invQ         (chInv[gi]),
      .oeQ          (chOe[gi]),
      .pin          (pulseOut[gi])
    );
  end

endmodule

// File: rtl/twin_pulse_chk.sv
module twin_pulse_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fastTick,
  input logic              slowTick,
  input logic              cfgWr,
  input logic [NUM_CH-1:0] cfgEnable,
  input logic [NUM_CH-1:0] cfgInvert,
  input logic [NUM_CH-1:0] cfgPinOe,
  input logic [NUM_CH-1:0] pulseOut,
  input logic [NUM_CH-1:0] cfgErr,
  input logic [NUM_CH-1:0] chRun,
  input logic [NUM_CH-1:0] chInv,
  input logic [NUM_CH-1:0] chOe
);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
    // R8: unsupported tick combination keeps the pin at its inactive level
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfgErr[gi] |-> (pulseOut[gi] == (chOe[gi] & chInv[gi])));

    // R9: disabling write forces the inactive level next cycle
    p_stop_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfgWr && !cfgEnable[gi]) |=>
        (pulseOut[gi] == ($past(cfgPinOe[gi]) & $past(cfgInvert[gi]))));

    // R7: closed gate drives 0
    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chOe[gi] |-> !pulseOut[gi]);

    // R2: outside the running phase (idle or delay) the pin is inactive
    p_idle_inactive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chRun[gi] |-> (pulseOut[gi] == (chOe[gi] & chInv[gi])));
  end

  // R11: nothing moves without a tick or a write
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fastTick && !slowTick && !cfgWr) |=> $stable(pulseOut));

endmodule

bind twin_pulse_gen twin_pulse_chk #(.NUM_CH(NUM_CH)) u_twin_pulse_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fastTick  (fastTick),
  .slowTick  (slowTick),
  .cfgWr     (cfgWr),
  .cfgEnable (cfgEnable),
  .cfgInvert (cfgInvert),
  .cfgPinOe  (cfgPinOe),
  .pulseOut  (pulseOut),
  .cfgErr    (cfgErr),
  .chRun     (chRun),
  .chInv     (chInv),
  .chOe      (chOe)
);

// File: tb/test_twin_pulse_gen.sv
`timescale 1ns/1ps
module test_twin_pulse_gen;

  localparam int NUM_CH = 2;
  localparam int CNT_W  = 8;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    fastTick = 1'b0;
  logic                    slowTick = 1'b0;
  logic                    cfgWr = 1'b0;
  logic [NUM_CH-1:0]       cfgEnable = '0;
  logic [NUM_CH*CNT_W-1:0] cfgDelay = '0;
  logic [NUM_CH*CNT_W-1:0] cfgOnTime = '0;
  logic [NUM_CH*CNT_W-1:0] cfgPeriod = '0;
  logic [NUM_CH-1:0]       cfgOnSlow = '0;
  logic [NUM_CH-1:0]       cfgPrdSlow = '0;
  logic [NUM_CH-1:0]       cfgInvert = '0;
  logic [NUM_CH-1:0]       cfgPinOe = '0;
  logic [NUM_CH-1:0]       pulseOut;
  logic [NUM_CH-1:0]       cfgErr;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  twin_pulse_gen #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_twin_pulse_gen (
    .clk(clk), .rst_n(rst_n), .fastTick(fastTick), .slowTick(slowTick),
    .cfgWr(cfgWr), .cfgEnable(cfgEnable), .cfgDelay(cfgDelay),
    .cfgOnTime(cfgOnTime), .cfgPeriod(cfgPeriod), .cfgOnSlow(cfgOnSlow),
    .cfgPrdSlow(cfgPrdSlow), .cfgInvert(cfgInvert), .cfgPinOe(cfgPinOe),
    .pulseOut(pulseOut), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input logic got, input logic exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  // arithmetic expectation of the active level after k period ticks
  function automatic logic expAct(int k, int d, int on, int p);
    if (k < d || p == 0) return 1'b0;
    return ((k - d) % p) < on;
  endfunction

  task automatic setCh(input int c, input int d, input int on, input int p,
                       input logic onS, input logic prdS, input logic inv,
                       input logic oe, input logic en);
    cfgDelay[c*CNT_W +: CNT_W]  = CNT_W'(d);
    cfgOnTime[c*CNT_W +: CNT_W] = CNT_W'(on);
    cfgPeriod[c*CNT_W +: CNT_W] = CNT_W'(p);
    cfgOnSlow[c]  = onS;
    cfgPrdSlow[c] = prdS;
    cfgInvert[c]  = inv;
    cfgPinOe[c]   = oe;
    cfgEnable[c]  = en;
  endtask

  task automatic doWrite();
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic tickFast();
    fastTick = 1'b1;
    @(negedge clk);
    fastTick = 1'b0;
  endtask

  task automatic tickSlow();
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired before all requirements were exercised");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin : stim
    logic held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset pin0", pulseOut[0], 1'b0);
    check("R9 reset pin1", pulseOut[1], 1'b0);
    check("R8 reset err", |cfgErr, 1'b0);

    // Sweep: both channels started in one write (R1), same fast tick for
    // on-time and period, checked after every tick (R2 R3 R4 R6).
    for (int d = 0; d < 4; d++)
      for (int on = 0; on < 5; on++)
        for (int p = 0; p < 5; p++)
          for (int inv = 0; inv < 2; inv++) begin
            setCh(0, d, on, p, 1'b0, 1'b0, inv[0], 1'b1, 1'b0);
            setCh(1, 3 - d, on, p, 1'b0, 1'b0, !inv[0], 1'b1, 1'b0);
            doWrite();
            check("R9 stopped ch0", pulseOut[0], inv[0]);
            check("R9 stopped ch1", pulseOut[1], !inv[0]);
            cfgEnable = 2'b11;
            doWrite();
            for (int k = 0; k < 13; k++) begin
              if (k > 0) tickFast();
              check("R2 R3 R4 R6 R1 ch0", pulseOut[0], expAct(k, d, on, p) ^ inv[0]);
              check("R2 R3 R4 R6 R1 ch1", pulseOut[1], expAct(k, 3 - d, on, p) ^ !inv[0]);
            end
          end

    // R5: on-time fast, period and delay slow
    setCh(0, 1, 3, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    setCh(1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    doWrite();
    cfgEnable[0] = 1'b1;
    doWrite();
    check("R5 delay phase", pulseOut[0], 1'b0);
    tickFast();
    check("R5 delay ignores fast tick", pulseOut[0], 1'b0);
    tickSlow();
    check("R5 delay ends on slow tick", pulseOut[0], 1'b1);
    tickFast(); tickFast();
    check("R5 on-time after 2 fast", pulseOut[0], 1'b1);
    tickFast();
    check("R5 on-time over after 3 fast", pulseOut[0], 1'b0);
    tickSlow();
    check("R5 mid period", pulseOut[0], 1'b0);
    tickSlow();
    check("R5 period wrap on slow", pulseOut[0], 1'b1);
    tickSlow();
    check("R5 slow tick leaves on-time", pulseOut[0], 1'b1);

    // R8: unsupported combination, both polarities
    setCh(0, 0, 2, 4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    setCh(1, 0, 2, 4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    doWrite();
    cfgEnable = 2'b11;
    doWrite();
    check("R8 err flag ch0", cfgErr[0], 1'b1);
    check("R8 no err ch1", cfgErr[1], 1'b0);
    for (int k = 0; k < 4; k++) begin
      check("R8 held inactive", pulseOut[0], 1'b0);
      tickFast();
      tickSlow();
    end
    setCh(0, 0, 2, 4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    doWrite();
    cfgEnable[0] = 1'b1;
    doWrite();
    tickSlow();
    check("R8 held inactive inverted", pulseOut[0], 1'b1);

    // R7: gate closed hides an active inverted and non-inverted channel
    setCh(0, 0, 4, 4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    setCh(1, 0, 4, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    doWrite();
    cfgEnable = 2'b11;
    doWrite();
    check("R7 gate off inv", pulseOut[0], 1'b0);
    check("R7 gate off active", pulseOut[1], 1'b0);
    cfgPinOe = 2'b11;
    doWrite();
    check("R7 gate on inv", pulseOut[0], 1'b0);
    check("R7 gate on active", pulseOut[1], 1'b1);

    // R10: rewrite while running does not restart
    setCh(0, 0, 2, 4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    setCh(1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    doWrite();
    cfgEnable[0] = 1'b1;
    doWrite();
    tickFast(); tickFast();
    check("R10 off part", pulseOut[0], 1'b0);
    doWrite();
    check("R10 no restart", pulseOut[0], 1'b0);
    tickFast();
    check("R10 continues", pulseOut[0], 1'b0);
    tickFast();
    check("R10 wrap keeps phase", pulseOut[0], 1'b1);

    // R9: disable then re-enable restarts from delay
    cfgEnable[0] = 1'b0;
    doWrite();
    check("R9 disabled", pulseOut[0], 1'b0);
    setCh(0, 2, 1, 3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    doWrite();
    check("R9 restart delay", pulseOut[0], 1'b0);
    tickFast();
    check("R9 restart delay 1", pulseOut[0], 1'b0);
    tickFast();
    check("R9 restart active", pulseOut[0], 1'b1);

    // R11: no tick, no write: pins hold
    held = pulseOut[0];
    repeat (6) @(negedge clk);
    check("R11 hold", pulseOut[0], held);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule